// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of an SPI mode 0 link in front of a byte-addressed nonvolatile memory model. It runs on a fast system clock and oversamples chip select, serial clock, serial input and the pause input. It collects an 8-bit instruction, then a 16-bit address where one is needed, then data bytes. All fields are shifted most significant bit first. A small synchronous RAM holds the array contents for reads. That RAM is filled through a write port owned by a separate page-program engine.

The block produces no programming timing itself. Write-enable changes, status-register writes and array bytes leave as single-cycle requests toward the engine and the protection logic. A commit pulse marks the chip-select rise that starts programming. Two inputs come back from outside: a permit that comes from the protection decision, and a busy flag that reflects the internal write cycle. A serial read continues for as long as the clock runs, and its address wraps around the whole array. The pause input freezes a transfer in place, with the output turned off. An unrecognised instruction silences the block until chip select is raised and lowered again.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, and whenever `cs_n` has been high for two clocks, `so_oe` is 0 and no request pulse is issued.
- R2: Instructions are matched with bit 3 ignored and bits 7..4 zero: low bits 110 pulse `wren_set`, low bits 100 pulse `wren_clr`. So both 0x06 and 0x0E set the latch.
- R3: A byte that matches none of the six instructions leaves `so_oe` at 0 and produces no request for the rest of that selection. The next selection decodes normally.
- R4: Instruction 0x03 is followed by a 16-bit address. Data bytes are then shifted out MSB first, and `so` changes after falling SCK. `so_oe` stays 0 during the instruction and the address.
- R5: Read data runs on from byte to byte, incrementing the address and wrapping from 2^ADDR_W-1 to 0. Address bits at and above ADDR_W are ignored.
- R6: Instruction 0x05 returns `stat_in`. The value is reloaded at the start of every byte for as long as the selection lasts.
- R7: Instruction 0x02 is followed by an address. Each complete data byte pulses `wr_req` with `wr_addr` and `wr_data`. The low PAGE_W address bits increment and wrap inside the page. `wr_commit` pulses once when CS rises on a byte boundary after at least one byte.
- R8: A data byte that completes while `wr_permit` is 0 yields no `wr_req`. If no byte was accepted, no `wr_commit` follows.
- R9: Instruction 0x01 followed by one byte pulses `wrsr_req` once, with that byte on `wrsr_data`.
- R10: While `prog_busy` is 1 at decode, every instruction except 0x05 is dropped in the same way as an unrecognised one.
- R11: `hold_n` taken low while SCK is low pauses the transfer. During the pause `so_oe` is 0 and SCK edges are ignored. Raising `hold_n` while SCK is low resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| prog_busy | input | 1 | Internal write cycle in progress |
| wr_permit | input | 1 | Protection decision for the current write byte |
| stat_in | input | 8 | Status byte to return |
| wren_set | output | 1 | Pulse: set write-enable latch |
| wren_clr | output | 1 | Pulse: clear write-enable latch |
| wrsr_req | output | 1 | Pulse: status-register write |
| wrsr_data | output | 8 | Status byte to write |
| wr_req | output | 1 | Pulse: one array byte to program |
| wr_addr | output | ADDR_W | Array address of that byte |
| wr_data | output | 8 | Data of that byte |
| wr_commit | output | 1 | Pulse: end of a write selection, start programming |
| ram_we | input | 1 | Array write strobe from the page engine |
| ram_waddr | input | ADDR_W | Array write address from the page engine |
| ram_wdata | input | 8 | Array write data from the page engine |

## Verification
The assertions take for granted that the serial inputs are already synchronous to `clk`. They also assume each SCK level lasts at least three clocks and that `hold_n` changes only while SCK is low. Under those conditions one SCK edge produces exactly one edge event, and the read RAM has settled before the next falling edge. The stimulus always holds each SCK level for four clocks. It moves chip select and the pause input only during the SCK low phase, and it changes `stat_in`, `prog_busy` and `wr_permit` only between bytes.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDOUT,
    PH_SROUT,
    PH_WRIN,
    PH_SRIN,
    PH_MUTE
  } phase_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WREN,
    OP_WRDI,
    OP_RDSR,
    OP_WRSR,
    OP_READ,
    OP_WRITE
  } op_t;

  // bit 3 is a don't-care, upper nibble must be zero
  function automatic op_t decode_op(input logic [7:0] b);
    op_t r;
    r = OP_NONE;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  r = OP_WREN;
        3'b100:  r = OP_WRDI;
        3'b101:  r = OP_RDSR;
        3'b001:  r = OP_WRSR;
        3'b011:  r = OP_READ;
        3'b010:  r = OP_WRITE;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_mem_pins.sv
module spi_mem_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic sel,
  output logic cs_stop,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic held
);

  logic cs_s, cs_p, sck_s, sck_p, hold_s;
  logic held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (cs_s) begin
      held_d = 1'b0;
    end else if (!sck_s) begin
      held_d = !hold_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s   <= 1'b1;
      cs_p   <= 1'b1;
      sck_s  <= 1'b0;
      sck_p  <= 1'b0;
      si_s   <= 1'b0;
      hold_s <= 1'b1;
      held_q <= 1'b0;
    end else begin
      cs_s   <= cs_n;
      cs_p   <= cs_s;
      sck_s  <= sck;
      sck_p  <= sck_s;
      si_s   <= si;
      hold_s <= hold_n;
      held_q <= held_d;
    end
  end

  assign sel      = !cs_s;
  assign held     = held_q;
  assign cs_stop  = cs_s && !cs_p;
  assign sck_rise = sck_s && !sck_p && !held_q && !cs_s;
  assign sck_fall = !sck_s && sck_p && !held_q && !cs_s;

endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_mem_seq.sv
module spi_mem_seq
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              cs_stop,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_s,
  input  logic              held,
  input  logic              prog_busy,
  input  logic              wr_permit,
  input  logic [7:0]        stat_in,
  input  logic [7:0]        ram_rdata,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              so,
  output logic              so_oe,
  output logic              wren_set,
  output logic              wren_clr,
  output logic              wrsr_req,
  output logic [7:0]        wrsr_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_END = CNT_W'(15);

  phase_t            phase_q, phase_d;
  logic              is_rd_q, is_rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [6:0]        in_sr_q, in_sr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        out_sr_q, out_sr_d;
  logic [2:0]        obit_q, obit_d;
  logic              out_act_q, out_act_d;
  logic              so_q, so_d;
  logic              wr_any_q, wr_any_d;
  logic              wren_set_d, wren_clr_d, wrsr_req_d, wr_req_d, commit_d;
  logic [7:0]        wrsr_data_d, wr_data_d;
  logic [ADDR_W-1:0] wr_addr_d;
  logic [7:0]        byte_in, ld_byte;
  op_t               op_dec;

  assign byte_in = {in_sr_q, si_s};
  assign op_dec  = decode_op(byte_in);
  assign ld_byte = (phase_q == PH_RDOUT) ? ram_rdata : stat_in;

  always_comb begin
    phase_d     = phase_q;
    is_rd_d     = is_rd_q;
    cnt_d       = cnt_q;
    in_sr_d     = in_sr_q;
    addr_d      = addr_q;
    out_sr_d    = out_sr_q;
    obit_d      = obit_q;
    out_act_d   = out_act_q;
    so_d        = so_q;
    wr_any_d    = wr_any_q;
    wren_set_d  = 1'b0;
    wren_clr_d  = 1'b0;
    wrsr_req_d  = 1'b0;
    wr_req_d    = 1'b0;
    commit_d    = 1'b0;
    wrsr_data_d = wrsr_data;
    wr_data_d   = wr_data;
    wr_addr_d   = wr_addr;

    if (!sel) begin
      if (cs_stop && phase_q == PH_WRIN && wr_any_q && cnt_q == '0) begin
        commit_d = 1'b1;
      end
      phase_d   = PH_OPC;
      cnt_d     = '0;
      obit_d    = '0;
      out_act_d = 1'b0;
      wr_any_d  = 1'b0;
    end else begin
      if (sck_rise) begin
        case (phase_q)
          PH_OPC: begin
            in_sr_d = byte_in[6:0];
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == BYTE_END) begin
              cnt_d = '0;
              if (op_dec == OP_NONE || (prog_busy && op_dec != OP_RDSR)) begin
                phase_d = PH_MUTE;
              end else begin
                case (op_dec)
                  OP_WREN: begin wren_set_d = 1'b1; phase_d = PH_MUTE; end
                  OP_WRDI: begin wren_clr_d = 1'b1; phase_d = PH_MUTE; end
                  OP_RDSR: phase_d = PH_SROUT;
                  OP_WRSR: phase_d = PH_SRIN;
                  OP_READ: begin is_rd_d = 1'b1; phase_d = PH_ADDR; end
                  default: begin is_rd_d = 1'b0; phase_d = PH_ADDR; end
                endcase
              end
            end
          end
          PH_ADDR: begin
            addr_d = {addr_q[ADDR_W-2:0], si_s};
            cnt_d  = cnt_q + 1'b1;
            if (cnt_q == ADDR_END) begin
              cnt_d   = '0;
              phase_d = is_rd_q ? PH_RDOUT : PH_WRIN;
            end
          end
          PH_SRIN: begin
            in_sr_d = byte_in[6:0];
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == BYTE_END) begin
              wrsr_req_d  = 1'b1;
              wrsr_data_d = byte_in;
              cnt_d       = '0;
              phase_d     = PH_MUTE;
            end
          end
          PH_WRIN: begin
            in_sr_d = byte_in[6:0];
            cnt_d   = cnt_q + 1'b1;
            if (cnt_q == BYTE_END) begin
              cnt_d  = '0;
              addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
              if (wr_permit) begin
                wr_req_d  = 1'b1;
                wr_addr_d = addr_q;
                wr_data_d = byte_in;
                wr_any_d  = 1'b1;
              end
            end
          end
          default: ;
        endcase
      end

      if (sck_fall && (phase_q == PH_RDOUT || phase_q == PH_SROUT)) begin
        out_act_d = 1'b1;
        obit_d    = obit_q + 1'b1;
        if (obit_q == '0) begin
          so_d     = ld_byte[7];
          out_sr_d = {ld_byte[6:0], 1'b0};
          if (phase_q == PH_RDOUT) begin
            addr_d = addr_q + 1'b1;
          end
        end else begin
          so_d     = out_sr_q[7];
          out_sr_d = {out_sr_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_OPC;
      is_rd_q   <= 1'b0;
      cnt_q     <= '0;
      in_sr_q   <= '0;
      addr_q    <= '0;
      out_sr_q  <= '0;
      obit_q    <= '0;
      out_act_q <= 1'b0;
      so_q      <= 1'b0;
      wr_any_q  <= 1'b0;
      wren_set  <= 1'b0;
      wren_clr  <= 1'b0;
      wrsr_req  <= 1'b0;
      wrsr_data <= '0;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      is_rd_q   <= is_rd_d;
      cnt_q     <= cnt_d;
      in_sr_q   <= in_sr_d;
      addr_q    <= addr_d;
      out_sr_q  <= out_sr_d;
      obit_q    <= obit_d;
      out_act_q <= out_act_d;
      so_q      <= so_d;
      wr_any_q  <= wr_any_d;
      wren_set  <= wren_set_d;
      wren_clr  <= wren_clr_d;
      wrsr_req  <= wrsr_req_d;
      wrsr_data <= wrsr_data_d;
      wr_req    <= wr_req_d;
      wr_addr   <= wr_addr_d;
      wr_data   <= wr_data_d;
      wr_commit <= commit_d;
    end
  end

  assign ram_raddr = addr_q;
  assign so        = so_q;
  assign so_oe     = out_act_q && !held && sel;

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic              prog_busy,
  input  logic              wr_permit,
  input  logic [7:0]        stat_in,
  output logic              wren_set,
  output logic              wren_clr,
  output logic              wrsr_req,
  output logic [7:0]        wrsr_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  input  logic              ram_we,
  input  logic [ADDR_W-1:0] ram_waddr,
  input  logic [7:0]        ram_wdata
);

  logic rst_m, rst_sync_n;
  logic sel, cs_stop, sck_rise, sck_fall, si_s, held;
  logic [ADDR_W-1:0] ram_raddr;
  logic [7:0]        ram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  spi_mem_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (si),
    .hold_n   (hold_n),
    .sel      (sel),
    .cs_stop  (cs_stop),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s),
    .held     (held)
  );

  spi_mem_seq #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel       (sel),
    .cs_stop   (cs_stop),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .si_s      (si_s),
    .held      (held),
    .prog_busy (prog_busy),
    .wr_permit (wr_permit),
    .stat_in   (stat_in),
    .ram_rdata (ram_rdata),
    .ram_raddr (ram_raddr),
    .so        (so),
    .so_oe     (so_oe),
    .wren_set  (wren_set),
    .wren_clr  (wren_clr),
    .wrsr_req  (wrsr_req),
    .wrsr_data (wrsr_data),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit)
  );

  spi_mem_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (8)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic hold_n,
  input logic so_oe,
  input logic prog_busy,
  input logic wr_permit,
  input logic wren_set,
  input logic wren_clr,
  input logic wrsr_req,
  input logic wr_req
);

  // R1
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && $past(cs_n, 2)) |-> (!so_oe && !wr_req));

  // R2
  latch_pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wren_set && wren_clr));

  // R7
  write_byte_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R8
  write_needs_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(wr_permit));

  // R9
  status_write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_req |=> !wrsr_req);

  // R10
  busy_blocks_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wren_set |-> !$past(prog_busy));

  // R11
  pause_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!hold_n, 2) && $past(!sck, 2) && $past(!hold_n) && !hold_n) |-> !so_oe);

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .hold_n    (hold_n),
  .so_oe     (so_oe),
  .prog_busy (prog_busy),
  .wr_permit (wr_permit),
  .wren_set  (wren_set),
  .wren_clr  (wren_clr),
  .wrsr_req  (wrsr_req),
  .wr_req    (wr_req)
);

// File: tb/spi_mem_front_bench.sv
`timescale 1ns/1ps
module spi_mem_front_bench;

  localparam int ADDR_W = 10;
  localparam int HALF   = 4;
  localparam int NVEC   = 6;
  // {address sent, effective address}
  localparam logic [25:0] RVEC [NVEC] = '{
    {16'h0000, 10'h000},
    {16'h0123, 10'h123},
    {16'hFC05, 10'h005},
    {16'h03FF, 10'h3FF},
    {16'h8200, 10'h200},
    {16'h7ABC, 10'h2BC}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, sck, si, hold_n;
  logic so, so_oe;
  logic prog_busy, wr_permit;
  logic [7:0] stat_in;
  logic wren_set, wren_clr, wrsr_req, wr_req, wr_commit;
  logic [7:0] wrsr_data, wr_data;
  logic [ADDR_W-1:0] wr_addr;
  logic ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [7:0] ram_wdata;

  int errors = 0;
  int checks = 0;
  bit oe_seen;
  int n_set = 0, n_clr = 0, n_wrsr = 0, n_wr = 0, n_commit = 0;
  logic [7:0] last_wrsr;
  logic [ADDR_W-1:0] log_a [8];
  logic [7:0] log_d [8];

  always #2.5 clk = ~clk;

  spi_mem_front #(.ADDR_W(ADDR_W), .PAGE_W(6)) u_spi_mem_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .prog_busy(prog_busy), .wr_permit(wr_permit),
    .stat_in(stat_in), .wren_set(wren_set), .wren_clr(wren_clr),
    .wrsr_req(wrsr_req), .wrsr_data(wrsr_data), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  always @(negedge clk) begin
    if (wren_set) n_set++;
    if (wren_clr) n_clr++;
    if (wrsr_req) begin n_wrsr++; last_wrsr = wrsr_data; end
    if (wr_req) begin
      if (n_wr < 8) begin log_a[n_wr] = wr_addr; log_d[n_wr] = wr_data; end
      n_wr++;
    end
    if (wr_commit) n_commit++;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + (a >> 3)) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    oe_seen = 1'b0;
    cs_n = 1'b0;
    wait_clks(HALF);
  endtask

  task automatic cs_end();
    wait_clks(HALF);
    cs_n = 1'b1;
    wait_clks(3 * HALF);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    si = b;
    wait_clks(HALF);
    r = so;
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1;
    wait_clks(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_xfer(tx[i], rx[i]);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] dummy;
    xfer(op, dummy);
    xfer(a[15:8], dummy);
    xfer(a[7:0], dummy);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rx, rx2, rx3;
    logic b;
    int base;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    prog_busy = 1'b0; wr_permit = 1'b1; stat_in = 8'h00;
    ram_we = 1'b0; ram_waddr = '0; ram_wdata = '0;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(4);

    // R1 reset state
    check("R1 oe after reset", int'(so_oe), 0);
    check("R1 no pulses after reset", n_set + n_clr + n_wrsr + n_wr + n_commit, 0);

    for (int i = 0; i < (1 << ADDR_W); i++) begin
      ram_we = 1'b1; ram_waddr = ADDR_W'(i); ram_wdata = pat(i);
      wait_clks(1);
    end
    ram_we = 1'b0;

    // R4 R5 vector walk: single-byte reads, upper address bits ignored
    for (int v = 0; v < NVEC; v++) begin
      cs_begin();
      send_hdr(8'h03, RVEC[v][25:10]);
      check("R4 oe low during header", int'(oe_seen), 0);
      xfer(8'h00, rx);
      check("R5 read data", int'(rx), int'(pat(int'(RVEC[v][9:0]))));
      check("R4 oe during data", int'(oe_seen), 1);
      cs_end();
      check("R1 oe after deselect", int'(so_oe), 0);
    end

    // R5 burst wrap at top of array
    cs_begin();
    send_hdr(8'h03, 16'h03FE);
    xfer(8'h00, rx); xfer(8'h00, rx2); xfer(8'h00, rx3);
    cs_end();
    check("R5 burst byte0", int'(rx), int'(pat(10'h3FE)));
    check("R5 burst byte1", int'(rx2), int'(pat(10'h3FF)));
    check("R5 wrap to zero", int'(rx3), int'(pat(0)));

    // R2 bit 3 don't-care on read opcode
    cs_begin();
    send_hdr(8'h0B, 16'h0042);
    xfer(8'h00, rx);
    cs_end();
    check("R2 opcode 0x0B reads", int'(rx), int'(pat(10'h042)));

    // R2 latch instructions
    cs_begin(); xfer(8'h06, rx); cs_end();
    cs_begin(); xfer(8'h0E, rx); cs_end();
    check("R2 wren_set count", n_set, 2);
    cs_begin(); xfer(8'h04, rx); cs_end();
    check("R2 wren_clr count", n_clr, 1);

    // R6 status read, reloaded per byte
    stat_in = 8'hA5;
    cs_begin();
    xfer(8'h05, rx);
    xfer(8'h00, rx);
    stat_in = 8'h3C;
    xfer(8'h00, rx2);
    cs_end();
    check("R6 status byte0", int'(rx), 8'hA5);
    check("R6 status byte1", int'(rx2), 8'h3C);

    // R9 status register write
    cs_begin(); xfer(8'h01, rx); xfer(8'h8C, rx); cs_end();
    check("R9 wrsr count", n_wrsr, 1);
    check("R9 wrsr data", int'(last_wrsr), 8'h8C);

    // R7 page write with in-page wrap
    base = n_wr;
    cs_begin();
    send_hdr(8'h02, 16'h013E);
    xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx);
    cs_end();
    check("R7 wr_req count", n_wr - base, 3);
    check("R7 addr0", int'(log_a[base]), 10'h13E);
    check("R7 addr1", int'(log_a[base + 1]), 10'h13F);
    check("R7 page wrap addr2", int'(log_a[base + 2]), 10'h100);
    check("R7 data2", int'(log_d[base + 2]), 8'h33);
    check("R7 commit", n_commit, 1);

    // R8 write refused by protection
    wr_permit = 1'b0;
    base = n_wr;
    cs_begin();
    send_hdr(8'h02, 16'h0010);
    xfer(8'h55, rx); xfer(8'h66, rx);
    cs_end();
    wr_permit = 1'b1;
    check("R8 no wr_req", n_wr - base, 0);
    check("R8 no commit", n_commit, 1);

    // R3 invalid opcode mutes the selection, next one works
    cs_begin();
    xfer(8'h87, rx);
    send_hdr(8'h03, 16'h0001);
    xfer(8'h06, rx);
    xfer(8'h00, rx);
    cs_end();
    check("R3 oe stays low", int'(oe_seen), 0);
    check("R3 no latch pulse", n_set, 2);
    cs_begin(); xfer(8'h00, rx); xfer(8'h06, rx); cs_end();
    check("R3 zero opcode ignored", n_set, 2);
    cs_begin();
    send_hdr(8'h03, 16'h0001);
    xfer(8'h00, rx);
    cs_end();
    check("R3 recovers next select", int'(rx), int'(pat(1)));

    // R10 busy: only status read accepted
    prog_busy = 1'b1;
    cs_begin(); xfer(8'h06, rx); cs_end();
    check("R10 wren dropped", n_set, 2);
    cs_begin();
    send_hdr(8'h03, 16'h0005);
    xfer(8'h00, rx);
    cs_end();
    check("R10 read dropped oe", int'(oe_seen), 0);
    stat_in = 8'hFF;
    cs_begin(); xfer(8'h05, rx); xfer(8'h00, rx); cs_end();
    check("R10 status while busy", int'(rx), 8'hFF);
    prog_busy = 1'b0;

    // R11 pause mid-byte
    cs_begin();
    send_hdr(8'h03, 16'h0077);
    for (int i = 7; i >= 5; i--) begin bit_xfer(1'b0, b); rx[i] = b; end
    hold_n = 1'b0;
    wait_clks(HALF);
    check("R11 oe low in pause", int'(so_oe), 0);
    for (int k = 0; k < 2; k++) begin
      sck = 1'b1; wait_clks(HALF);
      sck = 1'b0; wait_clks(HALF);
    end
    check("R11 oe low after clocks", int'(so_oe), 0);
    hold_n = 1'b1;
    wait_clks(HALF);
    for (int i = 4; i >= 0; i--) begin bit_xfer(1'b0, b); rx[i] = b; end
    xfer(8'h00, rx2);
    cs_end();
    check("R11 byte intact", int'(rx), int'(pat(10'h077)));
    check("R11 next byte", int'(rx2), int'(pat(10'h078)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule